// File: doc/BRIEF.md
# Completion-Gated Store Queue

This block sits between the store execution stage and the data cache. Each executed store enters with its address, 64-bit data, byte-enable mask and instruction tag, and waits in a small circular buffer. An external completion interface later names the tag of the oldest uncommitted store, which marks that store as safe to perform. Committed stores leave through a single cache write port in exactly the order they arrived. The head entry is always the next one written.

A newly accepted store becomes visible on the write port no earlier than three cycles after acceptance. It appears at that point only if it has been committed and every older store has already been written. A flush pulse drops every uncommitted store in one cycle and keeps the committed ones, which still drain normally. A synchronisation request is acknowledged only while the queue is empty, so that every store before it has reached the cache.

Both the store input and the write port are valid/ready streams. A transfer happens on a cycle where valid and ready are both high. On the write port, once valid is raised it stays high with a stable payload until ready is seen. The input side drops ready when the queue is full or a flush is present. A store that is not taken must be presented again. Commit, flush and the synchronisation pair are plain level signals sampled every cycle.

Top module: `store_commit_queue`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `wr_valid` is 0 and `sync_ack` is 0 while `sync_req` is 0.
- R2: At most one store is accepted per cycle. `st_ready` is 0 exactly when 4 stores are held or `flush` is 1.
- R3: No store is presented on the write port before a commit naming it has been taken.
- R4: A commit (`cmt_valid` = 1) marks the oldest uncommitted store only when `cmt_tag` equals that store's tag. Otherwise the commit is ignored and no store becomes writable.
- R5: Stores are written in acceptance order, and the write payload (`wr_addr`, `wr_data`, `wr_be`) is the head entry's. The order of writes equals the order of commits.
- R6: A store accepted in cycle t, committed in cycle t+1, and with an empty queue ahead of it, raises `wr_valid` in cycle t+3 and not before.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, the next cycle keeps `wr_valid` at 1 with an unchanged payload.
- R8: A `flush` removes all uncommitted stores at the next clock edge. Committed stores remain and are still written.
- R9: `sync_ack` is 1 exactly when `sync_req` is 1 and the queue holds no store.
- R10: A commit that matches in the same cycle as `flush` takes effect first, so that store survives the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Executed store present |
| st_ready | output | 1 | Queue can take a store this cycle |
| st_addr | input | 32 | Store address |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Byte enables |
| st_tag | input | 4 | Instruction tag of the store |
| cmt_valid | input | 1 | Completion names a tag this cycle |
| cmt_tag | input | 4 | Tag allowed to commit |
| flush | input | 1 | Drop all uncommitted stores |
| sync_req | input | 1 | Synchronisation request (level) |
| sync_ack | output | 1 | All prior stores written |
| wr_valid | output | 1 | Cache write presented |
| wr_ready | input | 1 | Cache write port free |
| wr_addr | output | 32 | Write address |
| wr_data | output | 64 | Write data |
| wr_be | output | 8 | Write byte enables |

## Verification
The embedded assertions check these properties on every cycle:
- the occupancy bound;
- that a write is only offered while a committed entry exists;
- the stability of the write port under back-pressure;
- the emptiness behind `sync_ack`;
- that a fresh entry cannot be written on the next cycle;
- that after a flush only committed entries remain.

Properties that span several stores can only be shown by the bench's scenarios:
- the exact three-cycle latency;
- that rejected commit tags are ignored;
- that commit and flush interact correctly in the same cycle;
- that the sequence of written addresses matches the sequence of commits under random traffic.

// File: rtl/stq_pkg.sv
package stq_pkg;
  localparam int STQ_AW    = 32;
  localparam int STQ_DW    = 64;
  localparam int STQ_TAGW  = 4;
  localparam int STQ_DEPTH = 4;
  localparam int STQ_LAT   = 3;

  // width of a saturating age counter that must reach lat-1
  function automatic int age_width(input int lat);
    int w;
    w = 1;
    while ((1 << w) < lat) w++;
    return w;
  endfunction
endpackage

// File: rtl/stq_slot.sv
module stq_slot #(
  parameter int AW   = 32,
  parameter int DW   = 64,
  parameter int TAGW = 4,
  parameter int LAT  = 3,
  localparam int BW  = DW / 8,
  localparam int AGW = stq_pkg::age_width(LAT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            mark,
  input  logic [AW-1:0]   in_addr,
  input  logic [DW-1:0]   in_data,
  input  logic [BW-1:0]   in_be,
  input  logic [TAGW-1:0] in_tag,
  output logic [AW-1:0]   q_addr,
  output logic [DW-1:0]   q_data,
  output logic [BW-1:0]   q_be,
  output logic [TAGW-1:0] q_tag,
  output logic            q_cmt,
  output logic            age_ok
);
  localparam logic [AGW-1:0] AGE_MAX = AGW'(LAT - 1);

  logic [AGW-1:0] age;

  always_ff @(posedge clk) begin
    if (load) begin
      q_addr <= in_addr;
      q_data <= in_data;
      q_be   <= in_be;
      q_tag  <= in_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cmt <= 1'b0;
      age   <= '0;
    end else if (load) begin
      q_cmt <= 1'b0;
      age   <= '0;
    end else begin
      if (mark) q_cmt <= 1'b1;
      if (age != AGE_MAX) age <= age + 1'b1;
    end
  end

  assign age_ok = (age == AGE_MAX);

  AST_FRESH_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !age_ok); // R6
  AST_MARK_UNCOMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> !q_cmt); // R4
endmodule

// File: rtl/stq_order.sv
module stq_order #(
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          hit,
  input  logic          flush,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [PW-1:0] cptr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] ccnt
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [PW-1:0] head_n, tail_n, cptr_n;
  logic [CW-1:0] cnt_n, ccnt_n;

  always_comb begin
    head_n = pop  ? wrap_inc(head) : head;
    cptr_n = hit  ? wrap_inc(cptr) : cptr;
    tail_n = push ? wrap_inc(tail) : tail;
    ccnt_n = ccnt + CW'(hit) - CW'(pop);
    cnt_n  = cnt + CW'(push) - CW'(pop);
    if (flush) begin
      tail_n = cptr_n;
      cnt_n  = ccnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cptr <= '0;
      cnt  <= '0;
      ccnt <= '0;
    end else begin
      head <= head_n;
      tail <= tail_n;
      cptr <= cptr_n;
      cnt  <= cnt_n;
      ccnt <= ccnt_n;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R2
  AST_CMT_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
    ccnt <= cnt); // R4
  AST_POP_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> ccnt != '0); // R3
  AST_FLUSH_KEEPS_CMT: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == ccnt); // R8
endmodule

// File: rtl/store_commit_queue.sv
module store_commit_queue #(
  parameter int AW    = stq_pkg::STQ_AW,
  parameter int DW    = stq_pkg::STQ_DW,
  parameter int TAGW  = stq_pkg::STQ_TAGW,
  parameter int DEPTH = stq_pkg::STQ_DEPTH,
  parameter int LAT   = stq_pkg::STQ_LAT,
  localparam int BW   = DW / 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [BW-1:0]   st_be,
  input  logic [TAGW-1:0] st_tag,
  input  logic            cmt_valid,
  input  logic [TAGW-1:0] cmt_tag,
  input  logic            flush,
  input  logic            sync_req,
  output logic            sync_ack,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic [BW-1:0]   wr_be
);
  logic [PW-1:0] head, tail, cptr;
  logic [CW-1:0] cnt, ccnt;
  logic          push, pop, hit;

  logic [AW-1:0]   s_addr [DEPTH];
  logic [DW-1:0]   s_data [DEPTH];
  logic [BW-1:0]   s_be   [DEPTH];
  logic [TAGW-1:0] s_tag  [DEPTH];
  logic            s_cmt  [DEPTH];
  logic            s_ok   [DEPTH];

  assign st_ready = (cnt != CW'(DEPTH)) && !flush;
  assign push     = st_valid && st_ready;
  assign hit      = cmt_valid && (cnt != ccnt) && (s_tag[cptr] == cmt_tag);
  assign wr_valid = (cnt != '0) && s_cmt[head] && s_ok[head];
  assign pop      = wr_valid && wr_ready;
  assign wr_addr  = s_addr[head];
  assign wr_data  = s_data[head];
  assign wr_be    = s_be[head];
  assign sync_ack = sync_req && (cnt == '0);

  stq_order #(.DEPTH(DEPTH)) u_order (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .hit(hit), .flush(flush),
    .head(head), .tail(tail), .cptr(cptr), .cnt(cnt), .ccnt(ccnt)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    stq_slot #(.AW(AW), .DW(DW), .TAGW(TAGW), .LAT(LAT)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(push && (tail == PW'(i))),
      .mark(hit && (cptr == PW'(i))),
      .in_addr(st_addr), .in_data(st_data), .in_be(st_be), .in_tag(st_tag),
      .q_addr(s_addr[i]), .q_data(s_data[i]), .q_be(s_be[i]), .q_tag(s_tag[i]),
      .q_cmt(s_cmt[i]), .age_ok(s_ok[i])
    );
  end

  AST_WR_NEEDS_CMT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ccnt != '0); // R3
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)); // R7
  AST_SYNC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ack |-> !wr_valid && (ccnt == '0)); // R9
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH)) |-> !st_ready); // R2
endmodule

// File: tb/store_commit_queue_test.sv
`timescale 1ns/1ps
module store_commit_queue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, st_ready;
  logic [31:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_be = '0;
  logic [3:0]  st_tag = '0;
  logic        cmt_valid = 1'b0;
  logic [3:0]  cmt_tag = '0;
  logic        flush = 1'b0, sync_req = 1'b0, sync_ack;
  logic        wr_valid, wr_ready = 1'b1;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;

  always #2 clk = ~clk;

  store_commit_queue uut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be), .st_tag(st_tag),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .flush(flush),
    .sync_req(sync_req), .sync_ack(sync_ack), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  typedef struct {
    logic [31:0] a; logic [63:0] d; logic [7:0] m; logic [3:0] t; bit c; int age;
  } ment_t;
  ment_t       mq[$];
  logic [31:0] cord[$];
  int checks = 0, errors = 0, cyc_no = 0, wcount = 0;
  bit last_in_fire, last_wv;
  string wv_tag = "R3";
  logic [3:0]  next_tag = 4'd1;
  logic [31:0] next_addr = 32'h1000;

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %h exp %h (cycle %0d)", r, what, got, exp, cyc_no);
    end
  endtask

  task automatic cyc();
    bit er, ewv, eack, wf, hit;
    int k;
    @(negedge clk);
    cyc_no++;
    er   = (mq.size() < 4) && !flush;
    ewv  = (mq.size() > 0) && mq[0].c && (mq[0].age >= 2);
    eack = sync_req && (mq.size() == 0);
    chk(st_ready == er, "R2", "st_ready", 64'(st_ready), 64'(er));
    chk(wr_valid == ewv, wv_tag, "wr_valid", 64'(wr_valid), 64'(ewv));
    chk(sync_ack == eack, "R9", "sync_ack", 64'(sync_ack), 64'(eack));
    if (ewv && wr_valid) begin
      chk(wr_addr == mq[0].a, "R5", "wr_addr", 64'(wr_addr), 64'(mq[0].a));
      chk(wr_data == mq[0].d, "R5", "wr_data", wr_data, mq[0].d);
      chk(wr_be == mq[0].m, "R5", "wr_be", 64'(wr_be), 64'(mq[0].m));
    end
    last_in_fire = st_valid && er;
    last_wv = wr_valid;
    wf = ewv && wr_ready;
    if (wf && cord.size() > 0)
      chk(wr_addr == cord[0], "R5", "commit order addr", 64'(wr_addr), 64'(cord[0]));
    k = -1;
    foreach (mq[i]) if (k < 0 && !mq[i].c) k = i;
    hit = cmt_valid && (k >= 0) && (mq[k].t == cmt_tag);
    @(posedge clk);
    foreach (mq[i]) if (mq[i].age < 2) mq[i].age++;
    if (hit) begin
      mq[k].c = 1'b1;
      cord.push_back(mq[k].a);
    end
    if (wf) begin
      void'(mq.pop_front());
      void'(cord.pop_front());
      wcount++;
    end
    if (flush) while (mq.size() > 0 && !mq[$].c) void'(mq.pop_back());
    if (last_in_fire) mq.push_back('{st_addr, st_data, st_be, st_tag, 1'b0, 0});
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic send();
    st_valid = 1'b1;
    st_addr  = next_addr;
    st_data  = {next_addr, ~next_addr};
    st_be    = next_addr[10:3];
    st_tag   = next_tag;
    do cyc(); while (!last_in_fire);
    st_valid = 1'b0;
    next_tag++;
    next_addr += 32'h8;
  endtask

  function automatic int oldest_unc();
    foreach (mq[i]) if (!mq[i].c) return i;
    return -1;
  endfunction

  task automatic commit_oldest();
    int k;
    k = oldest_unc();
    cmt_valid = (k >= 0);
    cmt_tag = (k >= 0) ? mq[k].t : 4'd0;
    cyc();
    cmt_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    summary();
    $finish;
  end

  initial begin : stim
    int acc, seen, w0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(st_ready == 1'b1, "R1", "st_ready after reset", 64'(st_ready), 64'd1);
    chk(wr_valid == 1'b0, "R1", "wr_valid after reset", 64'(wr_valid), 64'd0);
    chk(sync_ack == 1'b0, "R1", "sync_ack after reset", 64'(sync_ack), 64'd0);
    @(posedge clk); #1;

    // R6: latency from acceptance to write
    wv_tag = "R6";
    send();
    acc = cyc_no;
    commit_oldest();
    seen = 0;
    for (int i = 0; i < 8 && seen == 0; i++) begin
      if (last_wv) seen = cyc_no;
      else cyc();
    end
    if (seen == 0 && last_wv) seen = cyc_no;
    chk(seen - acc == 3, "R6", "accept-to-write cycles", 64'(seen - acc), 64'd3);
    idle(3);

    // R2 / R4: fill, wrong tags ignored
    wv_tag = "R4";
    for (int i = 0; i < 4; i++) send();
    st_valid = 1'b1; st_addr = 32'hdead0000; st_tag = 4'hf;
    cyc();
    chk(last_in_fire == 1'b0, "R2", "store taken while full", 64'(last_in_fire), 64'd0);
    st_valid = 1'b0;
    cmt_valid = 1'b1; cmt_tag = mq[0].t ^ 4'h8;
    idle(4);
    cmt_valid = 1'b0;
    chk(wr_valid == 1'b0, "R4", "write after mismatched commit", 64'(wr_valid), 64'd0);

    // R7 / R5: commit in order with back-pressure
    wv_tag = "R7";
    wr_ready = 1'b0;
    for (int i = 0; i < 4; i++) commit_oldest();
    idle(3);
    w0 = wcount;
    wr_ready = 1'b1;
    idle(8);
    chk(wcount - w0 == 4, "R5", "writes after release", 64'(wcount - w0), 64'd4);

    // R8 / R10: flush keeps committed, same-cycle commit survives
    wv_tag = "R8";
    wr_ready = 1'b0;
    for (int i = 0; i < 3; i++) send();
    commit_oldest();
    wv_tag = "R10";
    cmt_valid = 1'b1; cmt_tag = mq[oldest_unc()].t; flush = 1'b1;
    cyc();
    cmt_valid = 1'b0; flush = 1'b0;
    w0 = wcount;
    wr_ready = 1'b1;
    idle(8);
    chk(wcount - w0 == 2, "R10", "writes surviving flush", 64'(wcount - w0), 64'd2);
    chk(st_ready == 1'b1, "R8", "queue empty after flush drain", 64'(st_ready), 64'd1);

    // R9: sync waits for drain
    wv_tag = "R9";
    send(); send();
    sync_req = 1'b1;
    commit_oldest(); commit_oldest();
    idle(6);
    chk(sync_ack == 1'b1, "R9", "sync_ack after drain", 64'(sync_ack), 64'd1);
    sync_req = 1'b0;
    idle(1);

    // random traffic (R3, R5)
    wv_tag = "R3";
    for (int n = 0; n < 4000; n++) begin
      int k;
      st_valid = ($urandom_range(0, 1) == 1);
      st_addr  = next_addr;
      st_data  = {$urandom(), $urandom()};
      st_be    = 8'($urandom());
      st_tag   = next_tag;
      k = oldest_unc();
      cmt_valid = ($urandom_range(0, 1) == 1) && (k >= 0);
      cmt_tag   = (k >= 0) ? (($urandom_range(0, 3) == 0) ? mq[k].t ^ 4'h8 : mq[k].t) : 4'd0;
      flush     = ($urandom_range(0, 39) == 0);
      sync_req  = ($urandom_range(0, 9) == 0);
      wr_ready  = ($urandom_range(0, 3) != 0);
      cyc();
      if (last_in_fire) begin
        next_tag++;
        next_addr += 32'h8;
      end
    end
    st_valid = 1'b0; cmt_valid = 1'b0; flush = 1'b0; sync_req = 1'b0; wr_ready = 1'b1;
    idle(4);
    summary();
    $finish;
  end
endmodule